// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned words over many clock cycles, using one adder that is only as wide as an operand. A caller presents a multiplicand and a multiplier and raises `start` while the unit is idle. From the next cycle the unit reports `busy` and carries out one add-and-shift step per clock. When the last step is done it raises `done` for one cycle, and the full double-width product can then be read as a high word and a low word.

The multiplicand is captured once and stays fixed for the whole operation. The multiplier and the growing product share one register that is twice the operand width. The multiplier starts in the lower half and the running sum starts in the upper half. In each step the bit that leaves at the bottom decides whether the multiplicand is added into the upper half. The adder's carry then enters the top bit as the whole register moves right by one place. The product stays on the outputs until the next accepted start.

Top module: `mul_shift_add`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0 and `prod_hi` and `prod_lo` are all zeros.
- R2: When `done` is 1, `{prod_hi, prod_lo}` equals the unsigned product of the multiplicand and multiplier captured at the accepted start. `prod_hi` holds bits 2W-1..W and `prod_lo` holds bits W-1..0.
- R3: `done` rises exactly W clock edges after the edge that accepts `start`, and it stays high for one cycle only.
- R4: `busy` is 1 from the cycle after an accepted start up to the cycle before `done`. Outside that span it is 0.
- R5: A `start` seen while `busy` is 1 is ignored. The running operation keeps its timing and gives the product of its original operands.
- R6: Operand inputs that change while `busy` is 1 have no effect on the result.
- R7: The adder's carry-out is kept, so the largest operands give a correct top word. For W=32, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE_00000001.
- R8: A zero operand on either side gives an all-zero product.
- R9: The small case 0b1000 times 0b1001 gives 0b1001000, which is 72.
- R10: After `done`, the product holds its value until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; taken only when idle |
| multiplicand | input | W | Multiplicand, captured at an accepted start |
| multiplier | input | W | Multiplier, captured at an accepted start |
| busy | output | 1 | High while the add/shift steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | W | Upper word of the product |
| prod_lo | output | W | Lower word of the product |

## Verification
The bench builds the block with its default width of 32 bits. At that width the all-ones operands drive a carry out of the adder on almost every step. The same width also holds the 4-bit worked case as a small product inside wide words. Because the default width fixes the step count at 32, the exact latency, the single-cycle `done` pulse, and a start or operand change injected part-way through a run can all be checked against fixed cycle numbers.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned DEF_WIDTH = 32;

  function automatic int unsigned cnt_bits(input int unsigned steps);
    return (steps <= 2) ? 1 : $clog2(steps);
  endfunction
endpackage

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl #(
  parameter int unsigned STEPS = mul_pkg::DEF_WIDTH
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = mul_pkg::cnt_bits(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] step_cnt;

  assign load = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (busy) begin
        if (step_cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_cnt <= step_cnt + 1'b1;
        end
      end
    end
  end

  // R3: done lasts a single cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3: done only ends a busy span
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R4: an accepted start makes the unit busy
  a_r4_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R5: a start while busy does not restart the counter
  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && step_cnt != LAST) |=> (step_cnt == $past(step_cnt) + 1'b1));
endmodule

// File: rtl/mul_seq_datapath.sv
module mul_seq_datapath #(
  parameter int unsigned W = mul_pkg::DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mcand_in,
  input  logic [W-1:0] mplier_in,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo
);
  logic [W-1:0] mcand_q;
  logic [W:0]   addend;
  logic [W:0]   sum;

  // Add the multiplicand only when the bit leaving at the bottom is set.
  assign addend = acc_lo[0] ? {1'b0, mcand_q} : '0;
  assign sum    = {1'b0, acc_hi} + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      acc_hi  <= '0;
      acc_lo  <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      acc_hi  <= '0;
      acc_lo  <= mplier_in;
    end else if (step) begin
      acc_hi <= sum[W:1];
      acc_lo <= {sum[0], acc_lo[W-1:1]};
    end
  end

  // R6: the captured multiplicand stays fixed during a run
  a_r6_mcand_stable: assert property (@(posedge clk) disable iff (rst)
    step |=> $stable(mcand_q));
  // R2: a fresh load clears the upper half
  a_r2_load_clears_hi: assert property (@(posedge clk) disable iff (rst)
    load |=> (acc_hi == '0));
  // R10: the idle register holds its value
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(acc_hi) && $stable(acc_lo)));
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int unsigned W = mul_pkg::DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] multiplicand,
  input  logic [W-1:0] multiplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  logic load;

  mul_seq_ctrl #(.STEPS(W)) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .busy  (busy),
    .done  (done)
  );

  mul_seq_datapath #(.W(W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (busy),
    .mcand_in  (multiplicand),
    .mplier_in (multiplier),
    .acc_hi    (prod_hi),
    .acc_lo    (prod_lo)
  );

  // R4: busy and done never overlap
  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
endmodule

// File: tb/mul_shift_add_tb_top.sv
module mul_shift_add_tb_top;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 8;
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    {32'h0000_0008, 32'h0000_0009},
    {32'h0000_0000, 32'h1234_5678},
    {32'h8765_4321, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'hDEAD_BEEF},
    {32'h8000_0000, 32'h0000_0002},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'hAAAA_AAAA, 32'h5555_5555}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [W-1:0] prod_hi, prod_lo;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_shift_add #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Starts a run and counts edges until done; optional mid-run disturbance.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb,
                     output int lat, output logic [63:0] prod);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 0; i < 100; i++) begin
      if (disturb && i == 10) begin
        mcand = ~a; mplier = ~b; start = 1'b1;
      end
      if (disturb && i == 12) start = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
    end
    prod = {prod_hi, prod_lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    summary();
  end

  initial begin
    int lat;
    logic [63:0] p, exp;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done, "R1 flags", {62'd0, busy, done}, 64'd0);
    chk({prod_hi, prod_lo} == 64'd0, "R1 product", {prod_hi, prod_lo}, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      run(VEC[v][63:32], VEC[v][31:0], 1'b0, lat, p);
      exp = 64'(VEC[v][63:32]) * 64'(VEC[v][31:0]);
      chk(p == exp, $sformatf("R2 vector %0d", v), p, exp);
      chk(lat == W, "R3 latency", 64'(lat), 64'(W));
    end

    // R9: small worked case
    run(32'd8, 32'd9, 1'b0, lat, p);
    chk(p == 64'd72, "R9 1000x1001", p, 64'd72);
    // R7: carry preserved
    run('1, '1, 1'b0, lat, p);
    chk(p == 64'hFFFF_FFFE_0000_0001, "R7 all-ones", p, 64'hFFFF_FFFE_0000_0001);
    // R8: zero operands
    run(32'hFFFF_FFFF, 32'd0, 1'b0, lat, p);
    chk(p == 64'd0, "R8 zero multiplier", p, 64'd0);

    // R3 and R4: done is one cycle; busy cleared after
    @(negedge clk);
    chk(!done, "R3 done single cycle", 64'(done), 64'd0);
    chk(!busy, "R4 idle after done", 64'(busy), 64'd0);

    // R4: busy during a run
    @(negedge clk);
    mcand = 32'd3; mplier = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R4 busy after start", 64'(busy), 64'd1);
    repeat (W) @(negedge clk);
    chk(!busy && {prod_hi, prod_lo} == 64'd15, "R4 run finished", {prod_hi, prod_lo}, 64'd15);

    // R5 and R6: start and operand changes mid-run are ignored
    run(32'h0001_0003, 32'h0000_F00D, 1'b1, lat, p);
    exp = 64'h0001_0003 * 64'h0000_F00D;
    chk(lat == W, "R5 latency unchanged", 64'(lat), 64'(W));
    chk(p == exp, "R6 original operands used", p, exp);

    // R10: product holds after done
    mcand = 32'h55; mplier = 32'h77;
    repeat (5) @(negedge clk);
    chk({prod_hi, prod_lo} == exp, "R10 hold", {prod_hi, prod_lo}, exp);

    // R1: reset mid-run clears state
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && {prod_hi, prod_lo} == 64'd0, "R1 reset mid-run",
        {prod_hi, prod_lo}, 64'd0);

    summary();
  end
endmodule